// File: doc/BRIEF.md
# Escalating Two-Stage Watchdog

This block is a watchdog whose down counter reloads from a programmable period. The first time the counter expires while running, it raises a pending interrupt. Software services the watchdog by clearing that interrupt, which also restarts the count. If the count expires a second time while the interrupt is still pending, the block can escalate to a one-cycle system reset pulse. After that pulse it returns to its power-on state.

Configuration goes through a small write-only register port. A lock register guards the period and control settings against stray writes, while the service (clear) path stays open. The interrupt can be masked or routed to a non-maskable output. Counting can be made to pause while a CPU debug-halt flag is high.

Top module: `stage_wdg`

## Requirements
- R1: After reset, `count` is all ones, the block is not running and is unlocked, and `irq`, `nmi` and `sysRst` are low.
- R2: A write to address 0 sets the period register and loads `count` with the written value on the same edge. While the run bit (control bit 0) is set, `count` drops by one per clock.
- R3: When `count` is zero on a running clock edge, the interrupt becomes pending and `count` reloads from the period register, so one period lasts period+1 cycles.
- R4: The pending interrupt appears on an output only when control bit 1 (interrupt enable) is set. It appears on `nmi` when control bit 3 is set and on `irq` otherwise, and never on both.
- R5: Any write to address 2 clears the pending interrupt and reloads `count` from the period register. This write is accepted even while locked.
- R6: With control bit 2 (reset enable) set, a zero-count edge while the interrupt is pending produces `sysRst` high for exactly one cycle. On that same edge the block returns to the state of R1.
- R7: With control bit 2 clear, a second expiry leaves the interrupt pending and produces no reset pulse.
- R8: A write of `UNLOCK_KEY` to address 3 unlocks the block, and any other value written there locks it. `locked` reads 1 when locked and 0 when unlocked. While locked, writes to address 0 (period) and address 1 (control) are ignored.
- R9: With control bit 4 (stall enable) set, a high `cpuHalt` freezes `count`. With bit 4 clear, `cpuHalt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 period, 1 control, 2 clear, 3 lock |
| wrData | input | CNT_W | Write data |
| cpuHalt | input | 1 | CPU debug-halt flag |
| count | output | CNT_W | Current counter value |
| locked | output | 1 | Lock state |
| irq | output | 1 | Maskable interrupt |
| nmi | output | 1 | Non-maskable interrupt |
| sysRst | output | 1 | One-cycle system reset pulse |

## Verification
The bench builds the block with the default 32-bit counter and the default unlock key. It programs periods of only 3 to 9 cycles, so that first and second expiries, the escalation edge and the service reload all occur within a few dozen clocks and can be checked cycle by cycle. Because the width stays at full size, the all-ones value that reset restores is checked as a genuine 32-bit value.

// File: rtl/stage_wdg_pkg.sv
package stage_wdg_pkg;

  localparam logic [1:0] ADDR_LOAD = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [1:0] ADDR_LOCK = 2'd3;
  localparam int CFG_W = 5;

  // control word layout, bit 0 at the right
  typedef struct packed {
    logic stallEn;
    logic nmiSel;
    logic rstEn;
    logic intEn;
    logic run;
  } wdgCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic reload;
    logic wipe;
  } wdgStrobe_t;

endpackage

// File: rtl/stage_wdg_dp.sv
module stage_wdg_dp
  import stage_wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdgStrobe_t       strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] countQ,
  output logic             isZero
);

  localparam logic [CNT_W-1:0] RST_CNT = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= RST_CNT;
    end else if (strobe.wipe) begin
      countQ <= RST_CNT;
    end else if (strobe.reload) begin
      countQ <= reloadVal;
    end else if (strobe.tick) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign isZero = (countQ == '0);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.reload && !strobe.wipe) |=> $stable(countQ));

  // R2
  dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.reload && !strobe.wipe) |=> (countQ == CNT_W'($past(countQ) - 1'b1)));

endmodule

// File: rtl/stage_wdg_ctrl.sv
module stage_wdg_ctrl
  import stage_wdg_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'h1ACC_E55D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             cpuHalt,
  input  logic             isZero,
  output wdgStrobe_t       strobe,
  output logic [CNT_W-1:0] reloadVal,
  output logic             locked,
  output logic             irq,
  output logic             nmi,
  output logic             sysRst
);

  localparam logic [CNT_W-1:0] RST_LOAD = '1;

  wdgCfg_t          cfgQ;
  logic [CNT_W-1:0] loadQ;
  logic             lockQ;
  logic             pendQ;
  logic             rstQ;

  logic wrLoad, wrCtrl, wrClr, wrLock;
  logic tick, timeout, escalate;

  always_comb begin
    wrLoad   = wrEn && (wrAddr == ADDR_LOAD) && !lockQ;
    wrCtrl   = wrEn && (wrAddr == ADDR_CTRL) && !lockQ;
    wrClr    = wrEn && (wrAddr == ADDR_CLR);
    wrLock   = wrEn && (wrAddr == ADDR_LOCK);
    tick     = cfgQ.run && !(cfgQ.stallEn && cpuHalt);
    timeout  = tick && isZero;
    escalate = timeout && pendQ && cfgQ.rstEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      loadQ <= RST_LOAD;
      lockQ <= 1'b0;
      pendQ <= 1'b0;
      rstQ  <= 1'b0;
    end else if (escalate) begin
      cfgQ  <= '0;
      loadQ <= RST_LOAD;
      lockQ <= 1'b0;
      pendQ <= 1'b0;
      rstQ  <= 1'b1;
    end else begin
      rstQ <= 1'b0;
      if (wrLoad) loadQ <= wrData;
      if (wrCtrl) cfgQ <= wdgCfg_t'(wrData[CFG_W-1:0]);
      if (wrLock) lockQ <= (wrData != UNLOCK_KEY);
      if (wrClr) pendQ <= 1'b0;
      else if (timeout) pendQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.tick   = tick;
    strobe.reload = wrClr || wrLoad || timeout;
    strobe.wipe   = escalate;
    reloadVal     = wrLoad ? wrData : loadQ;
  end

  assign locked = lockQ;
  assign irq    = pendQ && cfgQ.intEn && !cfgQ.nmiSel;
  assign nmi    = pendQ && cfgQ.intEn && cfgQ.nmiSel;
  assign sysRst = rstQ;

  // R6
  one_cycle_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |=> !sysRst);

  // R6
  rst_after_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |-> ($past(pendQ) && !lockQ && !cfgQ.run));

  // R8
  locked_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && wrEn && (wrAddr != ADDR_LOCK) && !escalate) |=> ($stable(cfgQ) && $stable(loadQ)));

  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(irq && nmi));

endmodule

// File: rtl/stage_wdg.sv
module stage_wdg
  import stage_wdg_pkg::*;
#(
  parameter int               CNT_W      = 32,
  parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'h1ACC_E55D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             cpuHalt,
  output logic [CNT_W-1:0] count,
  output logic             locked,
  output logic             irq,
  output logic             nmi,
  output logic             sysRst
);

  wdgStrobe_t       strobe;
  logic [CNT_W-1:0] reloadVal;
  logic             isZero;

  stage_wdg_ctrl #(.CNT_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuHalt(cpuHalt), .isZero(isZero), .strobe(strobe), .reloadVal(reloadVal),
    .locked(locked), .irq(irq), .nmi(nmi), .sysRst(sysRst)
  );

  stage_wdg_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reloadVal(reloadVal),
    .countQ(count), .isZero(isZero)
  );

endmodule

// File: tb/stage_wdg_tb.sv
module stage_wdg_tb;

  localparam int          W   = 32;
  localparam logic [31:0] KEY = 32'h1ACC_E55D;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic         cpuHalt = 1'b0;
  logic [W-1:0] count;
  logic         locked, irq, nmi, sysRst;

  int total = 0;
  int bad = 0;
  int rstSeen = 0;

  always #4 clk = ~clk;

  stage_wdg u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cpuHalt(cpuHalt), .count(count), .locked(locked), .irq(irq), .nmi(nmi),
    .sysRst(sysRst)
  );

  always @(negedge clk) if (sysRst) rstSeen++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; cpuHalt = 1'b0; wrEn = 1'b0;
    waitc(2);
    rstN = 1'b1;
    waitc(1);
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 count", count, ONES);
    chk("R1 locked", {31'd0, locked}, 0);
    chk("R1 outputs", {29'd0, irq, nmi, sysRst}, 0);
    waitc(3);
    chk("R1 idle count", count, ONES);
  endtask

  task automatic t_count_and_first();
    doReset();
    wr(0, 5);
    chk("R2 load", count, 5);
    wr(1, 32'h1);
    chk("R2 enable edge", count, 5);
    waitc(2);
    chk("R2 decrement", count, 3);
    waitc(3);
    chk("R3 zero", count, 0);
    waitc(1);
    chk("R3 reload", count, 5);
    chk("R4 masked irq", {30'd0, irq, nmi}, 0);
    wr(1, 32'h3);
    chk("R4 irq shown", {30'd0, irq, nmi}, 2);
    wr(1, 32'hB);
    chk("R4 nmi select", {30'd0, irq, nmi}, 1);
    waitc(12);
    chk("R7 still pending", {31'd0, nmi}, 1);
    chk("R7 no reset", rstSeen, 0);
    wr(2, 0);
    chk("R5 clear pending", {30'd0, irq, nmi}, 0);
    chk("R5 clear reload", count, 5);
  endtask

  task automatic t_escalate();
    doReset();
    rstSeen = 0;
    wr(0, 3);
    wr(1, 32'h7);
    chk("R6 start", count, 3);
    waitc(4);
    chk("R3 first pending", {31'd0, irq}, 1);
    chk("R3 first reload", count, 3);
    waitc(4);
    chk("R6 pulse", {31'd0, sysRst}, 1);
    chk("R6 count restored", count, ONES);
    chk("R6 outputs cleared", {30'd0, irq, nmi}, 0);
    chk("R6 unlocked", {31'd0, locked}, 0);
    waitc(1);
    chk("R6 pulse width", {31'd0, sysRst}, 0);
    chk("R6 stopped", count, ONES);
    chk("R6 pulse count", rstSeen, 1);
  endtask

  task automatic t_lock();
    doReset();
    wr(0, 7);
    wr(1, 32'h3);
    wr(3, 32'hDEAD_0001);
    chk("R8 locked", {31'd0, locked}, 1);
    chk("R8 count", count, 6);
    wr(0, 2);
    chk("R8 load ignored", count, 5);
    wr(1, 0);
    chk("R8 ctrl ignored", count, 4);
    wr(2, 0);
    chk("R5 clear while locked", count, 7);
    wr(3, KEY);
    chk("R8 unlocked", {31'd0, locked}, 0);
    chk("R8 count after unlock", count, 6);
    wr(1, 0);
    waitc(1);
    chk("R8 ctrl after unlock", count, 5);
  endtask

  task automatic t_stall();
    doReset();
    wr(0, 9);
    wr(1, 32'h11);
    chk("R9 start", count, 9);
    cpuHalt = 1'b1;
    waitc(3);
    chk("R9 frozen", count, 9);
    cpuHalt = 1'b0;
    waitc(2);
    chk("R9 resume", count, 7);
    wr(1, 32'h1);
    chk("R9 stall off", count, 6);
    cpuHalt = 1'b1;
    waitc(2);
    chk("R9 halt ignored", count, 4);
    cpuHalt = 1'b0;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_count_and_first();
    t_escalate();
    t_lock();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule